// File: doc/BRIEF.md
# Flag Threshold Offset Programming Unit

This unit keeps the two offsets that a FIFO's flag logic compares against: the almost-empty offset and the almost-full offset. Both offsets leave the unit as plain buses for the flag comparators. At master reset the unit loads a preset into both offsets. The preset is chosen by two select inputs and the level of the load strobe. In the same reset the unit latches which load method will be accepted afterwards: a bit-serial stream or whole words on the data input bus.

Once out of reset, software or a neighbouring controller can reprogram the two offsets through the chosen method. Either offset can be read back at any time over the data output bus, whichever method loaded it. A partial reset restarts the load, serial and readback sequencing. It leaves the offsets and the latched method as they were, so the FIFO can be flushed in mid-operation without programming the offsets again.

Loads and the method state are clocked by the write clock. Readback is clocked by the read clock. Both clocks sample the two reset inputs.

Top module: `flag_ofs_prog`

## Requirements
- R1: A write-clock edge with `mrst_n` low loads both offsets with 2^(i+3)-1, where i = {ld, cfg_sel[1], cfg_sel[0]}. This gives 7, 15, 31, 63, 127, 255, 511 or 1023 for i = 0 to 7.
- R2: The same master-reset edge latches the load method from `mr_serial_sel`: 1 selects serial loading and 0 selects parallel loading. The method then stays fixed until the next master reset.
- R3: In parallel method, each write-clock edge with `ld` and `wr_en` high copies `din` into one offset. The first such edge after any reset writes the almost-empty offset, the next writes the almost-full offset, and the two alternate from then on. The new value appears one cycle later and the other offset keeps its value.
- R4: In serial method, each write-clock edge with `ld` and `ser_en` high takes one bit from `ser_in`. The stream is 2*OFS_W bits long: the almost-empty offset first, least significant bit first, then the almost-full offset in the same order. Both offsets stay unchanged until the last bit, then both change together on that edge.
- R5: A read-clock edge with `ld` and `rd_en` high puts an offset on `dout` and raises `dout_vld` for the following cycle. The first readback after any reset returns the almost-empty offset, the next returns the almost-full offset, and the two alternate from then on. On any other edge `dout` holds and `dout_vld` is low.
- R6: Loads through the method that was not selected have no effect on the offsets. Neither do `wr_en`, `ser_en` or `rd_en` pulses while `ld` is low.
- R7: A partial reset (`prst_n` low, `mrst_n` high) returns the parallel slot, the serial bit count and the readback slot to their starting points. It leaves both offsets and the load method unchanged.
- R8: When both resets are low on the same edge, the master reset decides the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock: loads, resets and method state |
| rd_clk | input | 1 | Read clock: readback |
| mrst_n | input | 1 | Master reset, synchronous, active low |
| prst_n | input | 1 | Partial reset, synchronous, active low |
| ld | input | 1 | Load strobe; also preset select bit 2 during master reset |
| cfg_sel | input | 2 | Preset select bits 1:0, sampled at master reset |
| mr_serial_sel | input | 1 | Load method sampled at master reset (1 = serial) |
| wr_en | input | 1 | Parallel word load enable |
| ser_en | input | 1 | Serial bit load enable |
| ser_in | input | 1 | Serial data bit |
| din | input | OFS_W | Parallel offset value |
| rd_en | input | 1 | Readback enable |
| dout | output | OFS_W | Readback value |
| dout_vld | output | 1 | High for one cycle after each readback |
| ae_ofs | output | OFS_W | Almost-empty offset to the flag logic |
| af_ofs | output | OFS_W | Almost-full offset to the flag logic |

## Verification
The assertions assume that both reset inputs are synchronous to both clocks. They also assume that the offsets do not change while a readback on the read clock samples them. The stimulus meets both assumptions by driving the two clock ports from one clock and changing every input on the falling edge. The properties that compare the offsets across a cycle also rely on `ld` gating every load. For that reason the bench raises `wr_en` or `ser_en` without `ld` only in the cases that are meant to be ignored, and then checks that the offsets and `dout` did not move.

// File: rtl/ofs_pkg.sv
// Package ofs_pkg
// Shared types and preset arithmetic for the flag offset programming unit.
// Assumes offsets are at least 10 bits wide so the largest preset fits.
package ofs_pkg;

    localparam int unsigned NUM_PRESETS = 8;
    localparam int unsigned PRESET_IDX_W = $clog2(NUM_PRESETS);

    // Load method latched at master reset
    typedef enum logic {
        LOAD_PAR = 1'b0,
        LOAD_SER = 1'b1
    } load_mode_e;

    // Which offset the next parallel access touches
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } ofs_slot_e;

    // Preset i is a run of i+3 ones: 2^(i+3)-1
    function automatic int unsigned preset_value(input int unsigned idx);
        return (32'd8 << idx) - 32'd1;
    endfunction

endpackage

// File: rtl/ofs_preset_decode.sv
// Module ofs_preset_decode
// Turns the three reset-time select bits into the default offset value.
// Assumes OFS_W >= 10; larger presets are truncated otherwise.
module ofs_preset_decode #(
    parameter int unsigned OFS_W = 12
) (
    input  logic [ofs_pkg::PRESET_IDX_W-1:0] idx,
    output logic [OFS_W-1:0]                 value
);
    import ofs_pkg::*;

    logic [OFS_W-1:0] table_w [NUM_PRESETS];

    // One constant entry per preset, computed from its index
    for (genvar g = 0; g < NUM_PRESETS; g++) begin : g_entry
        assign table_w[g] = OFS_W'(preset_value(g));
    end

    // Select the entry named by the reset-time pins
    assign value = table_w[idx];

endmodule

// File: rtl/ofs_slot_ptr.sv
// Module ofs_slot_ptr
// One-bit pointer that alternates between the empty and full offset slot.
// Both resets are synchronous to clk and active low; either restarts it.
module ofs_slot_ptr (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic             step,
    output ofs_pkg::ofs_slot_e slot
);
    import ofs_pkg::*;

    ofs_slot_e slot_q;

    // Restart on either reset, otherwise toggle on each access
    always_ff @(posedge clk) begin
        if (!mrst_n || !prst_n) begin
            slot_q <= SLOT_EMPTY;
        end else if (step) begin
            slot_q <= (slot_q == SLOT_EMPTY) ? SLOT_FULL : SLOT_EMPTY;
        end
    end

    assign slot = slot_q;

endmodule

// File: rtl/ofs_serial_shift.sv
// Module ofs_serial_shift
// Collects a 2*OFS_W-bit serial stream, LSB first, empty offset first.
// Raises commit combinationally on the edge that carries the last bit and
// presents the two assembled offsets at the same time.
// Assumes shift_en is already qualified by the load method.
module ofs_serial_shift #(
    parameter int unsigned OFS_W = 12
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic             commit,
    output logic [OFS_W-1:0] ae_new,
    output logic [OFS_W-1:0] af_new
);
    localparam int unsigned TOTAL = 2 * OFS_W;
    localparam int unsigned CNT_W = $clog2(TOTAL);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TOTAL - 1);

    logic [TOTAL-1:0] shreg_q;
    logic [TOTAL-1:0] shreg_nxt;
    logic [CNT_W-1:0] cnt_q;

    // Next shift register value: new bit enters at the top
    always_comb begin
        shreg_nxt = {bit_in, shreg_q[TOTAL-1:1]};
    end

    // Shift register holds the bits received so far
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            shreg_q <= '0;
        end else if (prst_n && shift_en) begin
            shreg_q <= shreg_nxt;
        end
    end

    // Bit counter wraps after the last bit; either reset restarts it
    always_ff @(posedge clk) begin
        if (!mrst_n || !prst_n) begin
            cnt_q <= '0;
        end else if (shift_en) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign commit = shift_en && (cnt_q == LAST);
    assign ae_new = shreg_nxt[OFS_W-1:0];
    assign af_new = shreg_nxt[TOTAL-1:OFS_W];

endmodule

// File: rtl/ofs_readback.sv
// Module ofs_readback
// Read-clock readback path: on each request drives one offset on dout,
// empty offset first, and flags it valid for one cycle.
// Assumes the offsets are stable whenever a request is sampled.
module ofs_readback #(
    parameter int unsigned OFS_W = 12
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic             req,
    input  logic [OFS_W-1:0] ae_ofs,
    input  logic [OFS_W-1:0] af_ofs,
    output logic [OFS_W-1:0] dout,
    output logic             dout_vld
);
    import ofs_pkg::*;

    ofs_slot_e        slot;
    logic             step;
    logic [OFS_W-1:0] sel_val;
    logic [OFS_W-1:0] dout_q;
    logic             vld_q;

    assign step = req && mrst_n && prst_n;

    ofs_slot_ptr u_rd_slot (
        .clk    (clk),
        .mrst_n (mrst_n),
        .prst_n (prst_n),
        .step   (step),
        .slot   (slot)
    );

    // Pick the offset that the current slot names
    always_comb begin
        sel_val = (slot == SLOT_EMPTY) ? ae_ofs : af_ofs;
    end

    // Output data register: cleared by master reset, loaded on a request
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            dout_q <= '0;
        end else if (step) begin
            dout_q <= sel_val;
        end
    end

    // Valid strobe marks the cycle after each accepted request
    always_ff @(posedge clk) begin
        if (!mrst_n || !prst_n) begin
            vld_q <= 1'b0;
        end else begin
            vld_q <= req;
        end
    end

    assign dout     = dout_q;
    assign dout_vld = vld_q;

endmodule

// File: rtl/flag_ofs_prog.sv
// Module flag_ofs_prog
// Holds the almost-empty and almost-full offsets for a FIFO's flag logic.
// Master reset loads a preset and latches the load method; afterwards the
// offsets load serially or by word, and can be read back on the read clock.
// Partial reset restarts the sequencing and keeps offsets and method.
// Assumes both resets are synchronous to both clocks.
module flag_ofs_prog #(
    parameter int unsigned OFS_W = 12
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             mrst_n,
    input  logic             prst_n,
    input  logic             ld,
    input  logic [1:0]       cfg_sel,
    input  logic             mr_serial_sel,
    input  logic             wr_en,
    input  logic             ser_en,
    input  logic             ser_in,
    input  logic [OFS_W-1:0] din,
    input  logic             rd_en,
    output logic [OFS_W-1:0] dout,
    output logic             dout_vld,
    output logic [OFS_W-1:0] ae_ofs,
    output logic [OFS_W-1:0] af_ofs
);
    import ofs_pkg::*;

    load_mode_e       mode_q;
    logic             ser_mode;
    logic [OFS_W-1:0] preset_val;
    logic [OFS_W-1:0] ae_q;
    logic [OFS_W-1:0] af_q;
    logic             par_wr;
    logic             ser_shift;
    logic             ser_commit;
    logic [OFS_W-1:0] ser_ae;
    logic [OFS_W-1:0] ser_af;
    ofs_slot_e        wr_slot;

    assign ser_mode  = (mode_q == LOAD_SER);
    assign par_wr    = ld && wr_en && !ser_mode && mrst_n && prst_n;
    assign ser_shift = ld && ser_en && ser_mode && mrst_n && prst_n;

    ofs_preset_decode #(.OFS_W(OFS_W)) u_preset (
        .idx   ({ld, cfg_sel}),
        .value (preset_val)
    );

    ofs_serial_shift #(.OFS_W(OFS_W)) u_serial (
        .clk      (wr_clk),
        .mrst_n   (mrst_n),
        .prst_n   (prst_n),
        .shift_en (ser_shift),
        .bit_in   (ser_in),
        .commit   (ser_commit),
        .ae_new   (ser_ae),
        .af_new   (ser_af)
    );

    ofs_slot_ptr u_wr_slot (
        .clk    (wr_clk),
        .mrst_n (mrst_n),
        .prst_n (prst_n),
        .step   (par_wr),
        .slot   (wr_slot)
    );

    // Load method is fixed at master reset and kept through partial reset
    always_ff @(posedge wr_clk) begin
        if (!mrst_n) begin
            mode_q <= mr_serial_sel ? LOAD_SER : LOAD_PAR;
        end
    end

    // Almost-empty offset: preset, serial commit or parallel empty slot
    always_ff @(posedge wr_clk) begin
        if (!mrst_n) begin
            ae_q <= preset_val;
        end else if (ser_commit) begin
            ae_q <= ser_ae;
        end else if (par_wr && wr_slot == SLOT_EMPTY) begin
            ae_q <= din;
        end
    end

    // Almost-full offset: preset, serial commit or parallel full slot
    always_ff @(posedge wr_clk) begin
        if (!mrst_n) begin
            af_q <= preset_val;
        end else if (ser_commit) begin
            af_q <= ser_af;
        end else if (par_wr && wr_slot == SLOT_FULL) begin
            af_q <= din;
        end
    end

    ofs_readback #(.OFS_W(OFS_W)) u_readback (
        .clk      (rd_clk),
        .mrst_n   (mrst_n),
        .prst_n   (prst_n),
        .req      (ld && rd_en),
        .ae_ofs   (ae_q),
        .af_ofs   (af_q),
        .dout     (dout),
        .dout_vld (dout_vld)
    );

    assign ae_ofs = ae_q;
    assign af_ofs = af_q;

endmodule

// File: rtl/flag_ofs_prog_chk.sv
// Module flag_ofs_prog_chk
// Property checker bound into flag_ofs_prog; observes ports and the
// latched load method only.
module flag_ofs_prog_chk #(
    parameter int unsigned OFS_W = 12
) (
    input logic             wr_clk,
    input logic             rd_clk,
    input logic             mrst_n,
    input logic             prst_n,
    input logic             ld,
    input logic             wr_en,
    input logic             ser_en,
    input logic             rd_en,
    input logic             ser_mode,
    input logic [OFS_W-1:0] dout,
    input logic             dout_vld,
    input logic [OFS_W-1:0] ae_ofs,
    input logic [OFS_W-1:0] af_ofs
);

    AST_PRESET_SHAPE: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        $rose(mrst_n) |-> (ae_ofs == af_ofs) && $onehot({1'b0, ae_ofs} + 1'b1)); // R1

    AST_IDLE_HOLDS: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        !ld |=> $stable(ae_ofs) && $stable(af_ofs)); // R6

    AST_WRONG_PAR_IGNORED: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        (ser_mode && !ser_en) |=> $stable(ae_ofs) && $stable(af_ofs)); // R6

    AST_WRONG_SER_IGNORED: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        (!ser_mode && !wr_en) |=> $stable(ae_ofs) && $stable(af_ofs)); // R6

    AST_PARTIAL_KEEPS: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        !prst_n |=> $stable(ae_ofs) && $stable(af_ofs) && $stable(ser_mode)); // R7

    AST_MODE_STICKY: assert property (@(posedge wr_clk) disable iff (!mrst_n)
        1'b1 |=> $stable(ser_mode)); // R2

    AST_READ_VALID: assert property (@(posedge rd_clk) disable iff (!mrst_n || !prst_n)
        (ld && rd_en) |=> dout_vld); // R5

    AST_NO_READ_QUIET: assert property (@(posedge rd_clk) disable iff (!mrst_n)
        !(ld && rd_en) |=> !dout_vld && $stable(dout)); // R5

endmodule

bind flag_ofs_prog flag_ofs_prog_chk #(.OFS_W(OFS_W)) u_chk (
    .wr_clk   (wr_clk),
    .rd_clk   (rd_clk),
    .mrst_n   (mrst_n),
    .prst_n   (prst_n),
    .ld       (ld),
    .wr_en    (wr_en),
    .ser_en   (ser_en),
    .rd_en    (rd_en),
    .ser_mode (ser_mode),
    .dout     (dout),
    .dout_vld (dout_vld),
    .ae_ofs   (ae_ofs),
    .af_ofs   (af_ofs)
);

// File: tb/flag_ofs_prog_bench.sv
// Bench for flag_ofs_prog: sweeps presets, parallel and serial loads,
// readback order and both resets against an arithmetic model.
module flag_ofs_prog_bench;

    localparam int unsigned W    = 12;
    localparam int unsigned MASK = (1 << W) - 1;

    logic         clk = 1'b0;
    logic         mrst_n = 1'b0;
    logic         prst_n = 1'b1;
    logic         ld = 1'b0;
    logic [1:0]   cfg_sel = 2'b00;
    logic         mr_serial_sel = 1'b0;
    logic         wr_en = 1'b0;
    logic         ser_en = 1'b0;
    logic         ser_in = 1'b0;
    logic [W-1:0] din = '0;
    logic         rd_en = 1'b0;
    logic [W-1:0] dout;
    logic         dout_vld;
    logic [W-1:0] ae_ofs;
    logic [W-1:0] af_ofs;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Bench model
    int m_ae, m_af;
    bit m_wslot, m_rslot;

    always #4 clk = ~clk;

    flag_ofs_prog #(.OFS_W(W)) u_flag_ofs_prog (
        .wr_clk(clk), .rd_clk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .ld(ld), .cfg_sel(cfg_sel), .mr_serial_sel(mr_serial_sel),
        .wr_en(wr_en), .ser_en(ser_en), .ser_in(ser_in), .din(din),
        .rd_en(rd_en), .dout(dout), .dout_vld(dout_vld),
        .ae_ofs(ae_ofs), .af_ofs(af_ofs)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_ofs(input string tag);
        chk({tag, " ae"}, int'(ae_ofs), m_ae);
        chk({tag, " af"}, int'(af_ofs), m_af);
    endtask

    // Master reset with preset index and method; optional partial reset too
    task automatic do_mrst(input int idx, input bit ser, input bit with_prst);
        mrst_n = 1'b0; prst_n = with_prst ? 1'b0 : 1'b1;
        ld = idx[2]; cfg_sel = idx[1:0]; mr_serial_sel = ser;
        @(negedge clk);
        mrst_n = 1'b1; prst_n = 1'b1; ld = 1'b0;
        m_ae = (8 << idx) - 1; m_af = m_ae; m_wslot = 0; m_rslot = 0;
    endtask

    task automatic do_prst();
        prst_n = 1'b0;
        @(negedge clk);
        prst_n = 1'b1;
        m_wslot = 0; m_rslot = 0;
    endtask

    // Parallel word write; model updates only when it should take effect
    task automatic par_wr(input int v, input bit effective);
        ld = 1'b1; wr_en = 1'b1; din = W'(v);
        @(negedge clk);
        ld = 1'b0; wr_en = 1'b0;
        if (effective) begin
            if (!m_wslot) m_ae = v & MASK; else m_af = v & MASK;
            m_wslot = ~m_wslot;
        end
    endtask

    // Shift nbits of the {af,ae} stream, LSB of ae first
    task automatic ser_bits(input int a, input int f, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            ld = 1'b1; ser_en = 1'b1;
            ser_in = (i < W) ? a[i] : f[i - W];
            @(negedge clk);
        end
        ld = 1'b0; ser_en = 1'b0;
    endtask

    // Full serial load with check that nothing moves before the last bit
    task automatic ser_load(input int a, input int f, input string tag);
        ser_bits(a, f, 2 * W - 1);
        chk({tag, " R4 before last bit"}, int'(ae_ofs), m_ae);
        chk({tag, " R4 before last bit af"}, int'(af_ofs), m_af);
        ld = 1'b1; ser_en = 1'b1; ser_in = f[W-1];
        @(negedge clk);
        ld = 1'b0; ser_en = 1'b0;
        m_ae = a & MASK; m_af = f & MASK;
        chk_ofs({tag, " R4 after last bit"});
    endtask

    // One readback and its data, valid strobe and following quiet cycle
    task automatic readback(input string tag);
        int exp;
        exp = m_rslot ? m_af : m_ae;
        ld = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        ld = 1'b0; rd_en = 1'b0;
        m_rslot = ~m_rslot;
        chk({tag, " R5 dout"}, int'(dout), exp);
        chk({tag, " R5 vld"}, int'(dout_vld), 1);
        @(negedge clk);
        chk({tag, " R5 vld drop"}, int'(dout_vld), 0);
        chk({tag, " R5 dout hold"}, int'(dout), exp);
    endtask

    initial begin
        @(negedge clk);
        do_mrst(0, 1'b0, 1'b0);
        chk_ofs("reset state R1");
        chk("reset state R5 vld", int'(dout_vld), 0);

        // R1: preset sweep, both methods, read back each preset
        for (int idx = 0; idx < 8; idx++) begin
            do_mrst(idx, idx[0], 1'b0);
            chk_ofs($sformatf("R1 preset %0d", idx));
            readback("R1 preset rb ae");
            readback("R1 preset rb af");
        end

        // R3: parallel sweep with alternating slots and readback
        do_mrst(2, 1'b0, 1'b0);
        for (int k = 0; k < 20; k++) begin
            par_wr((k * 613 + 5) & MASK, 1'b1);
            chk_ofs("R3 par ae slot");
            par_wr((k * 1877 + 11) & MASK, 1'b1);
            chk_ofs("R3 par af slot");
            readback("R3 rb ae");
            readback("R3 rb af");
        end
        par_wr(0, 1'b1);
        par_wr(MASK, 1'b1);
        chk_ofs("R3 extremes");

        // R6: serial stream and unqualified strobes ignored in parallel method
        ser_bits(123, 456, 2 * W);
        chk_ofs("R6 serial in parallel method");
        wr_en = 1'b1; ser_en = 1'b1; din = W'(77);
        @(negedge clk);
        wr_en = 1'b0; ser_en = 1'b0;
        chk_ofs("R6 wr_en without ld");
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R6 rd_en without ld vld", int'(dout_vld), 0);

        // R7: partial reset in parallel method restarts slots, keeps offsets
        par_wr(900, 1'b1);
        readback("R7 pre");
        do_prst();
        chk_ofs("R7 par offsets kept");
        par_wr(333, 1'b1);
        chk_ofs("R7 par slot restarted");
        readback("R7 rb slot restarted");
        ser_bits(1, 2, 2 * W);
        chk_ofs("R7 R2 method kept parallel");

        // R4: serial method sweep
        do_mrst(3, 1'b1, 1'b0);
        chk_ofs("R2 serial preset");
        for (int k = 0; k < 8; k++) begin
            ser_load((k * 1291 + 3) & MASK, (k * 2741 + 9) & MASK, "R4 sweep");
            readback("R4 rb ae");
            readback("R4 rb af");
        end
        ser_load(MASK, 0, "R4 extremes");

        // R6: parallel writes ignored in serial method
        par_wr(55, 1'b0);
        chk_ofs("R6 par in serial method");

        // R7: partial reset mid-stream restarts the bit count
        ser_bits(4000, 4000, 5);
        do_prst();
        chk_ofs("R7 serial offsets kept");
        ser_load(2049, 1234, "R7 serial restart");
        par_wr(66, 1'b0);
        chk_ofs("R7 R2 method kept serial");

        // R8: master reset wins over partial reset
        do_mrst(5, 1'b0, 1'b1);
        chk_ofs("R8 both resets");
        par_wr(17, 1'b1);
        chk_ofs("R8 R2 method from master");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule